// File: doc/BRIEF.md
# Gated Event Counter with Snapshot Difference

This block counts rising edges of an asynchronous measured signal in a free-running counter made of two cascaded halves. The low half counts every edge. The high half advances when the low half wraps. Each rising edge of a gate signal takes a snapshot of the combined value.

The block reports the difference between that snapshot and the one before it. This is the number of measured-signal cycles in one gate period. The counter itself never restarts, so edges that arrive in the same cycle as a capture fall into the next period and none are lost.

A ready flag goes high when a new result is loaded. The consumer clears it with a one-cycle read strobe. Both the measured signal and the gate pass through two-flop synchronizers with edge detectors before they are used. Turning the result into a frequency is left to the consumer.

Top module: `gated_event_counter`

## Requirements
- R1: After reset, ready_o is 0 and count_o is 0.
- R2: Each rising edge of sig_in is counted exactly once, provided sig_in stays at each level for at least two clk cycles.
- R3: The running count is the high half shifted left by HALF_W plus the low half. The high half increments by one in the same cycle that the low half wraps from all ones to zero.
- R4: A capture happens only on a rising edge of gate_in. Holding gate_in high takes no further captures, and count_o and ready_o do not change.
- R5: count_o equals the newest snapshot minus the previous snapshot, modulo 2^(2*HALF_W). The first result after reset is taken relative to zero, and a wrap of the running count still yields the correct difference.
- R6: count_o and ready_o update on the third rising clk edge after gate_in rises: two synchronizer stages, then the capture register.
- R7: When ready_o is 1 and rd_ack is 1 at a clock edge with no capture, ready_o goes to 0 at that edge. count_o keeps its value until the next capture.
- R8: When a capture and rd_ack fall on the same edge, the capture wins: ready_o stays 1 and count_o takes the new value.
- R9: rd_ack while ready_o is 0 has no effect: ready_o stays 0 and count_o is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sig_in | input | 1 | Measured signal, asynchronous |
| gate_in | input | 1 | Gate signal, asynchronous; each rising edge takes a capture |
| rd_ack | input | 1 | One-cycle read strobe that clears ready_o |
| count_o | output | 2*HALF_W | Cycles counted in the last gate period |
| ready_o | output | 1 | A new result is available |

## Verification
The assertions assume sig_in and gate_in change slowly enough for the synchronizers to see each level, so no edge is merged or dropped. They also assume rd_ack is a plain strobe whose timing relative to a capture is arbitrary. The stimulus holds every level of sig_in for two clk cycles and lets the pipeline drain before each gate edge. That makes the expected count of each period exact. One directed case places rd_ack deliberately on the capture edge. The bench uses a narrow half width so that carries between the halves and wraps of the whole counter happen within a short run.

// File: rtl/evtcnt_pkg.sv
package evtcnt_pkg;
    localparam int DEF_HALF_W      = 16;
    localparam int DEF_SYNC_STAGES = 2;
endpackage

// File: rtl/evtcnt_sync_edge.sv
module evtcnt_sync_edge #(
    parameter int STAGES = evtcnt_pkg::DEF_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    // STAGES synchronizer flops followed by one history flop for edge detection
    typedef struct packed {
        logic [STAGES:0] sh;
    } sync_t;

    sync_t st_d, st_q;

    generate
        if (STAGES < 2) begin : g_bad
            initial $error("evtcnt_sync_edge needs at least two stages");
        end
    endgenerate

    always_comb begin
        st_d    = st_q;
        st_d.sh = {st_q.sh[STAGES-1:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise = st_q.sh[STAGES-1] & ~st_q.sh[STAGES];
endmodule

// File: rtl/evtcnt_cascade.sv
module evtcnt_cascade #(
    parameter int HALF_W = evtcnt_pkg::DEF_HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc,
    output logic [HALF_W-1:0] lo,
    output logic [HALF_W-1:0] hi
);
    typedef struct packed {
        logic [HALF_W-1:0] hi;
        logic [HALF_W-1:0] lo;
    } cnt_t;

    cnt_t st_d, st_q;
    logic carry;

    always_comb begin
        st_d  = st_q;
        carry = inc & (&st_q.lo);
        if (inc)   st_d.lo = st_q.lo + 1'b1;
        if (carry) st_d.hi = st_q.hi + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lo = st_q.lo;
    assign hi = st_q.hi;
endmodule

// File: rtl/evtcnt_capture.sv
module evtcnt_capture #(
    parameter int W = 2 * evtcnt_pkg::DEF_HALF_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap,
    input  logic         rd_ack,
    input  logic [W-1:0] total,
    output logic [W-1:0] diff,
    output logic         ready
);
    typedef struct packed {
        logic [W-1:0] snap;
        logic [W-1:0] diff;
        logic         rdy;
    } cap_t;

    cap_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_ack) st_d.rdy = 1'b0;
        if (cap) begin
            st_d.snap = total;
            st_d.diff = total - st_q.snap;
            st_d.rdy  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign diff  = st_q.diff;
    assign ready = st_q.rdy;
endmodule

// File: rtl/gated_event_counter.sv
module gated_event_counter #(
    parameter int HALF_W      = evtcnt_pkg::DEF_HALF_W,
    parameter int SYNC_STAGES = evtcnt_pkg::DEF_SYNC_STAGES
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sig_in,
    input  logic                  gate_in,
    input  logic                  rd_ack,
    output logic [2*HALF_W-1:0]   count_o,
    output logic                  ready_o
);
    localparam int W = 2 * HALF_W;

    logic              ev_pulse;
    logic              cap_pulse;
    logic [HALF_W-1:0] lo_cnt;
    logic [HALF_W-1:0] hi_cnt;
    logic [W-1:0]      total_cnt;

    evtcnt_sync_edge #(.STAGES(SYNC_STAGES)) u_sig_sync (
        .clk(clk), .rst_n(rst_n), .din(sig_in), .rise(ev_pulse)
    );

    evtcnt_sync_edge #(.STAGES(SYNC_STAGES)) u_gate_sync (
        .clk(clk), .rst_n(rst_n), .din(gate_in), .rise(cap_pulse)
    );

    evtcnt_cascade #(.HALF_W(HALF_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .inc(ev_pulse), .lo(lo_cnt), .hi(hi_cnt)
    );

    // both halves are read in one cycle, so a carry is never split
    assign total_cnt = {hi_cnt, lo_cnt};

    evtcnt_capture #(.W(W)) u_cap (
        .clk(clk), .rst_n(rst_n), .cap(cap_pulse), .rd_ack(rd_ack),
        .total(total_cnt), .diff(count_o), .ready(ready_o)
    );
endmodule

// File: rtl/evtcnt_checker.sv
module evtcnt_checker #(
    parameter int HALF_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                rd_ack,
    input logic                ready_o,
    input logic [2*HALF_W-1:0] count_o,
    input logic                cap_pulse,
    input logic                ev_pulse,
    input logic [HALF_W-1:0]   lo_cnt,
    input logic [HALF_W-1:0]   hi_cnt
);
    AST_CARRY_INTO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_pulse && (&lo_cnt)) |=> (lo_cnt == '0 && hi_cnt == HALF_W'($past(hi_cnt) + 1'b1))); // R3

    AST_HIGH_ONLY_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev_pulse && (&lo_cnt)) |=> $stable(hi_cnt)); // R3

    AST_READY_ONLY_FROM_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_pulse |=> !$rose(ready_o)); // R4

    AST_COUNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_pulse |=> $stable(count_o)); // R7

    AST_CAPTURE_SETS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        cap_pulse |=> ready_o); // R8

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && !cap_pulse) |=> !ready_o); // R7

    AST_IDLE_KEEPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_ack && !cap_pulse) |=> $stable(ready_o)); // R9
endmodule

bind gated_event_counter evtcnt_checker #(.HALF_W(HALF_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_ack(rd_ack), .ready_o(ready_o),
    .count_o(count_o), .cap_pulse(cap_pulse), .ev_pulse(ev_pulse),
    .lo_cnt(lo_cnt), .hi_cnt(hi_cnt)
);

// File: tb/sim_gated_event_counter.sv
module sim_gated_event_counter;
    localparam int CLK_PERIOD = 10;
    localparam int HW         = 4;
    localparam int W          = 2 * HW;
    localparam int NVEC       = 10;
    localparam int WATCHDOG   = 100000;

    // pulses per gate period, and the expected count modulo 2^W
    localparam int VEC_PULSES [NVEC] = '{5, 0, 15, 16, 17, 200, 255, 256, 300, 1};
    localparam int VEC_EXPECT [NVEC] = '{5, 0, 15, 16, 17, 200, 255, 0, 44, 1};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sig_in = 1'b0;
    logic         gate_in = 1'b0;
    logic         rd_ack = 1'b0;
    logic [W-1:0] count_o;
    logic         ready_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gated_event_counter #(.HALF_W(HW), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .gate_in(gate_in),
        .rd_ack(rd_ack), .count_o(count_o), .ready_o(ready_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            sig_in = 1'b1;
            repeat (2) @(negedge clk);
            sig_in = 1'b0;
            repeat (2) @(negedge clk);
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic gate_edge();
        gate_in = 1'b1;
        repeat (4) @(negedge clk);
        gate_in = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic read_out();
        rd_ack = 1'b1;
        @(negedge clk);
        rd_ack = 1'b0;
    endtask

    initial begin
        int cnt = 0;
        while (!done && cnt < WATCHDOG) begin
            @(posedge clk);
            cnt++;
        end
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", cnt, 0);
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int held;
        repeat (3) @(negedge clk);
        chk("R1 ready", ready_o, 0);
        chk("R1 count", count_o, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // vector table: R2 R3 R5
        for (int v = 0; v < NVEC; v++) begin
            pulses(VEC_PULSES[v]);
            gate_edge();
            chk("R5 ready", ready_o, 1);
            chk($sformatf("R2 R3 R5 vec%0d", v), count_o, VEC_EXPECT[v]);
            read_out();
            chk("R7 cleared", ready_o, 0);
            chk("R7 count held", count_o, VEC_EXPECT[v]);
        end

        // R9: read strobe while not ready
        read_out();
        chk("R9 ready", ready_o, 0);
        chk("R9 count", count_o, 1);

        // R6: exact latency of the result
        pulses(7);
        gate_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R6 not yet ready", ready_o, 0);
        chk("R6 not yet count", count_o, 1);
        @(negedge clk);
        chk("R6 ready at third edge", ready_o, 1);
        chk("R6 count at third edge", count_o, 7);
        repeat (2) @(negedge clk);
        read_out();

        // R4: gate held high gives no new capture
        pulses(5);
        chk("R4 no capture ready", ready_o, 0);
        chk("R4 no capture count", count_o, 7);
        gate_in = 1'b0;
        repeat (4) @(negedge clk);
        gate_edge();
        chk("R4 next capture", count_o, 5);
        read_out();

        // R8: read strobe on the capture edge
        pulses(9);
        gate_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rd_ack = 1'b1;
        @(negedge clk);
        rd_ack = 1'b0;
        chk("R8 ready kept", ready_o, 1);
        chk("R8 count new", count_o, 9);
        held = count_o;
        gate_in = 1'b0;
        repeat (3) @(negedge clk);
        read_out();
        chk("R8 later read clears", ready_o, 0);
        chk("R7 count after read", count_o, held);

        // R1: reset mid-run
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset ready", ready_o, 0);
        chk("R1 reset count", count_o, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        pulses(3);
        gate_edge();
        chk("R5 first after reset", count_o, 3);

        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule